// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block handles the short conditional branch instructions of a small byte-addressed microcontroller core. It steps through each instruction cycle as four phases, advancing one phase per strobe. It captures the fetched 16-bit word in the first phase and the 8-bit literal in the second. In the third phase it samples the ALU flags (carry, negative, zero, overflow) and decides whether the branch is taken. In the fourth phase it writes the program counter. A taken branch loads the counter with the sign-extended, word-scaled target. Any other outcome advances the counter by one instruction word (2 bytes).

A taken branch costs a second instruction cycle. That cycle is a bubble in which all four phases do nothing. The flush output is raised from the fourth phase of the taken branch until the bubble ends, so that the fetch stage discards the word it prefetched. A counter records every instruction cycle that completes, bubbles included.

The controller is a state machine with eight states. Four are execute states: `ST_X_Q1` (decode), `ST_X_Q2` (literal), `ST_X_Q3` (evaluate) and `ST_X_Q4` (PC write). Four are bubble states: `ST_B_Q1` to `ST_B_Q4`. The state moves only on a strobe. The transitions are:
- `ST_X_Q1` to `ST_X_Q2` to `ST_X_Q3` to `ST_X_Q4`.
- `ST_X_Q4` to `ST_X_Q1` when the branch is not taken.
- `ST_X_Q4` to `ST_B_Q1` when the branch is taken.
- `ST_B_Q1` to `ST_B_Q2` to `ST_B_Q3` to `ST_B_Q4` to `ST_X_Q1`.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes to this state: `pc` = 0, `flush` = 0, `bubble` = 0, `phase` = 0 (Q1) and `cycle_cnt` = 0.
- R2: `phase` encodes Q1..Q4 as 0..3. It advances by one, wrapping from 3 to 0, on each clock where `q_tick` is 1. It holds, together with `pc`, while `q_tick` is 0.
- R3: A word is a branch only when `instr[15:11]` = 5'b11100. For any other word, `pc` advances by 2 at the Q4 strobe, no bubble follows and `flush` stays 0.
- R4: `instr[10:9]` selects the flag tested (00 zero, 01 carry, 10 overflow, 11 negative). When `instr[8]` = 1 the test is inverted. The branch is taken when the selected flag XOR `instr[8]` is 1. The flags are sampled at the Q3 strobe.
- R5: A taken branch at address P loads `pc` with P + 2 + 2·n at its Q4 strobe, where n is the signed 8-bit value `instr[7:0]`, ranging from -128 to +127.
- R6: A branch that is not taken loads `pc` with P + 2 at its Q4 strobe and takes one instruction cycle.
- R7: A taken branch is followed by one bubble cycle. During that cycle `bubble` = 1 for all four phases and `pc` does not change. Execution then resumes at Q1.
- R8: `flush` is 1 during the Q4 of a taken branch and all through the following bubble cycle, and 0 at all other times.
- R9: `cycle_cnt` increments by one at the end of every instruction cycle, bubbles included. A taken branch therefore adds 2 and any other word adds 1.
- R10: `pc` is 21 bits wide and bit 0 is always 0. The target arithmetic wraps modulo 2^21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_tick | input | 1 | Phase strobe; each high clock advances one phase |
| instr | input | 16 | Fetched instruction word, captured at the Q1 strobe |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_ov | input | 1 | Overflow flag |
| pc | output | 21 | Program counter (byte address) |
| flush | output | 1 | Discard the prefetched word |
| bubble | output | 1 | The current instruction cycle is a no-operation |
| phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| cycle_cnt | output | 16 | Count of completed instruction cycles |

## Verification
The bench runs all eight condition codes with the selected flag at 0 and at 1. This separates the flag-select bits from the invert bit, and a swapped flag or a missing inversion shows up as a wrong `pc`.

The bench uses offsets +5, -3, +127 and -128. The negative offsets show whether the offset is sign-extended. The extremes show whether it is doubled. Running -128 from address 0 exercises the modulo-2^21 wrap.

Words just outside the branch prefix (0xE800 and 0xF123) and an all-zero word are given flags that would make any condition true. These cases show that the opcode match looks at all five prefix bits.

Taken and not-taken cases are interleaved. The flush window, the bubble cycle and the cycle count then distinguish a one-cycle outcome from a two-cycle one.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

    localparam int          IW        = 16;
    localparam int          OFS_W     = 8;
    localparam int          NUM_CC    = 8;
    localparam logic [4:0]  BR_PREFIX = 5'b11100;

    typedef struct packed {
        logic z;
        logic c;
        logic ov;
        logic n;
    } flags_t;

    typedef enum logic [2:0] {
        ST_X_Q1 = 3'b000,
        ST_X_Q2 = 3'b001,
        ST_X_Q3 = 3'b010,
        ST_X_Q4 = 3'b011,
        ST_B_Q1 = 3'b100,
        ST_B_Q2 = 3'b101,
        ST_B_Q3 = 3'b110,
        ST_B_Q4 = 3'b111
    } cbr_state_e;

    function automatic logic pick_flag(input flags_t f, input logic [1:0] sel);
        logic r;
        unique case (sel)
            2'b00:   r = f.z;
            2'b01:   r = f.c;
            2'b10:   r = f.ov;
            default: r = f.n;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbr_cond_eval.sv
`timescale 1ns/1ps
module cbr_cond_eval
    import cbr_pkg::*;
(
    input  logic [IW-1:0] word,
    input  flags_t        flags,
    output logic          is_branch,
    output logic          cond_true
);

    logic [NUM_CC-1:0] hit;

    // one comparator per condition code; only the code in the word can hit
    for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
        localparam logic [2:0] CC = 3'(k);
        assign hit[k] = (word[10:8] == CC) && (pick_flag(flags, CC[2:1]) ^ CC[0]);
    end

    assign is_branch = (word[IW-1:IW-5] == BR_PREFIX);
    assign cond_true = |hit;

endmodule

// File: rtl/cbr_target_calc.sv
`timescale 1ns/1ps
module cbr_target_calc
    import cbr_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  tgt_pc
);

    localparam int EXT_W = PC_W - OFS_W - 1;

    logic [PC_W-1:0] ofs_bytes;

    // sign-extend the word offset and scale to bytes
    assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    assign seq_pc    = pc_cur + PC_W'(2);
    assign tgt_pc    = seq_pc + ofs_bytes;

endmodule

// File: rtl/cbr_cycle_counter.sv
`timescale 1ns/1ps
module cbr_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc |=> count == $past(count) + 1'b1);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));

endmodule

// File: rtl/cond_branch_unit.sv
`timescale 1ns/1ps
module cond_branch_unit
    import cbr_pkg::*;
#(
    parameter int PC_W  = 21,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_tick,
    input  logic [15:0]      instr,
    input  logic             flag_c,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_ov,
    output logic [PC_W-1:0]  pc,
    output logic             flush,
    output logic             bubble,
    output logic [1:0]       phase,
    output logic [CNT_W-1:0] cycle_cnt
);

    cbr_state_e        state, state_nxt;
    logic [IW-1:0]     ir;
    logic [OFS_W-1:0]  ofs_q;
    logic              taken_q;
    logic [PC_W-1:0]   tgt_q;
    logic [PC_W-1:0]   seq_pc, tgt_pc;
    logic              is_branch, cond_true;
    logic              cyc_end;
    flags_t            flags;

    assign flags = '{z: flag_z, c: flag_c, ov: flag_ov, n: flag_n};

    cbr_cond_eval u_cond (
        .word      (ir),
        .flags     (flags),
        .is_branch (is_branch),
        .cond_true (cond_true)
    );

    cbr_target_calc #(.PC_W(PC_W)) u_tgt (
        .pc_cur (pc),
        .ofs    (ofs_q),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    assign cyc_end = q_tick && (state == ST_X_Q4 || state == ST_B_Q4);

    cbr_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (cyc_end),
        .count (cycle_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_X_Q1;
        else
            state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (q_tick) begin
            unique case (state)
                ST_X_Q1: state_nxt = ST_X_Q2;
                ST_X_Q2: state_nxt = ST_X_Q3;
                ST_X_Q3: state_nxt = ST_X_Q4;
                ST_X_Q4: state_nxt = taken_q ? ST_B_Q1 : ST_X_Q1;
                ST_B_Q1: state_nxt = ST_B_Q2;
                ST_B_Q2: state_nxt = ST_B_Q3;
                ST_B_Q3: state_nxt = ST_B_Q4;
                ST_B_Q4: state_nxt = ST_X_Q1;
            endcase
        end
    end

    // phase-accurate datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            ir      <= '0;
            ofs_q   <= '0;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            pc      <= '0;
        end else if (q_tick) begin
            unique case (state)
                ST_X_Q1: ir      <= instr;
                ST_X_Q2: ofs_q   <= ir[OFS_W-1:0];
                ST_X_Q3: begin
                    taken_q <= is_branch && cond_true;
                    tgt_q   <= tgt_pc;
                end
                ST_X_Q4: pc      <= taken_q ? tgt_q : seq_pc;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_X_Q1: begin phase = 2'd0; bubble = 1'b0; flush = 1'b0;    end
            ST_X_Q2: begin phase = 2'd1; bubble = 1'b0; flush = 1'b0;    end
            ST_X_Q3: begin phase = 2'd2; bubble = 1'b0; flush = 1'b0;    end
            ST_X_Q4: begin phase = 2'd3; bubble = 1'b0; flush = taken_q; end
            ST_B_Q1: begin phase = 2'd0; bubble = 1'b1; flush = 1'b1;    end
            ST_B_Q2: begin phase = 2'd1; bubble = 1'b1; flush = 1'b1;    end
            ST_B_Q3: begin phase = 2'd2; bubble = 1'b1; flush = 1'b1;    end
            ST_B_Q4: begin phase = 2'd3; bubble = 1'b1; flush = 1'b1;    end
        endcase
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        q_tick |=> phase == $past(phase) + 2'd1);

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !q_tick |=> $stable(phase) && $stable(pc));

    // R7
    pc_write_q4_chk: assert property (@(posedge clk) disable iff (rst)
        !(q_tick && state == ST_X_Q4) |=> $stable(pc));

    // R8
    flush_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flush) |-> (phase == 2'd3 && !bubble));

    // R7
    bubble_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bubble) |-> (phase == 2'd0 && !flush));

    // R3
    nonbranch_chk: assert property (@(posedge clk) disable iff (rst)
        (q_tick && state == ST_X_Q3 && ir[IW-1:IW-5] != BR_PREFIX) |=> !flush);

    // R10
    pc_even_chk: assert property (@(posedge clk) disable iff (rst)
        pc[0] == 1'b0);

endmodule

// File: tb/cond_branch_unit_test.sv
`timescale 1ns/1ps
module cond_branch_unit_test;

    localparam int PC_W  = 21;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [CNT_W-1:0] cnt;
        logic             bub;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             q_tick = 1'b0;
    logic [15:0]      instr = '0;
    logic             flag_c = 1'b0, flag_n = 1'b0, flag_z = 1'b0, flag_ov = 1'b0;
    logic [PC_W-1:0]  pc;
    logic             flush, bubble;
    logic [1:0]       phase;
    logic [CNT_W-1:0] cycle_cnt;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    exp_t             sb[$];
    logic [PC_W-1:0]  m_pc;
    logic [CNT_W-1:0] m_cnt;

    always #2.5 clk = ~clk;

    cond_branch_unit #(.PC_W(PC_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .q_tick(q_tick), .instr(instr),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .flag_ov(flag_ov),
        .pc(pc), .flush(flush), .bubble(bubble), .phase(phase), .cycle_cnt(cycle_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        q_tick = 1'b1;
        @(negedge clk);
        q_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        q_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        sb.delete();
        m_pc  = '0;
        m_cnt = '0;
        @(negedge clk);
        chk(pc == 0 && flush == 0 && bubble == 0 && phase == 0 && cycle_cnt == 0,
            "R1 reset state", {pc, flush, bubble, phase}, 32'h0);
    endtask

    // driver: computes expectations, pushes them, and steps the phases
    task automatic run_instr(input logic [15:0] w, input bit c, input bit n, input bit z, input bit ov);
        bit              is_br, f, taken;
        logic [PC_W-1:0] nxt, start;
        exp_t            e;
        is_br = (w[15:11] == 5'b11100);
        unique case (w[10:9])
            2'b00: f = z;
            2'b01: f = c;
            2'b10: f = ov;
            default: f = n;
        endcase
        taken = is_br && (f ^ w[8]);
        start = m_pc;
        nxt   = taken ? (m_pc + 21'd2 + {{12{w[7]}}, w[7:0], 1'b0}) : (m_pc + 21'd2);
        e.pc = nxt; e.cnt = m_cnt + 1'b1; e.bub = taken;
        sb.push_back(e);
        if (taken) begin
            e.cnt = m_cnt + 2'd2; e.bub = 1'b0;
            sb.push_back(e);
        end
        m_pc  = nxt;
        m_cnt = m_cnt + (taken ? 2'd2 : 2'd1);

        instr = w; flag_c = c; flag_n = n; flag_z = z; flag_ov = ov;
        tick(); tick(); tick();
        // R2 phase reached Q4, pc untouched before Q4 strobe
        chk(phase == 2'd3 && pc == start, "R2 phase Q4 / pc held", {phase, pc}, {2'd3, start});
        // R8 flush in Q4 only for taken branch; R3 nonbranch never flushes
        chk(flush == taken, is_br ? "R8 flush at Q4" : "R3 nonbranch flush low", flush, taken);
        tick();
        if (taken) begin
            for (int i = 0; i < 3; i++) begin
                // R7 bubble holds pc; R8 flush through bubble
                chk(bubble == 1 && flush == 1 && pc == nxt, "R7/R8 bubble phase",
                    {bubble, flush, pc}, {2'b11, nxt});
                tick();
            end
            chk(bubble == 1 && flush == 1 && phase == 2'd3, "R8 flush at bubble Q4",
                {bubble, flush, phase}, 4'b1111);
            tick();
        end
        chk(flush == 0 && bubble == 0 && phase == 0, "R8 flush low after cycle",
            {flush, bubble, phase}, 32'h0);
    endtask

    // monitor: compares at every instruction-cycle boundary
    initial begin : monitor
        logic [1:0] prev;
        exp_t       e;
        prev = 2'd0;
        forever begin
            @(negedge clk);
            if (!rst && prev == 2'd3 && phase == 2'd0) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected cycle end", cycle_cnt, 32'h0);
                end else begin
                    e = sb.pop_front();
                    // R5/R6/R10 program counter value
                    chk(pc == e.pc, "R5/R6/R10 pc", pc, e.pc);
                    // R9 cycle count
                    chk(cycle_cnt == e.cnt, "R9 cycle count", cycle_cnt, e.cnt);
                    // R7 bubble follows only taken branch
                    chk(bubble == e.bub, "R7 bubble entry", bubble, e.bub);
                end
            end
            prev = rst ? 2'd0 : phase;
        end
    end

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        do_reset();

        // R2 hold without strobe
        repeat (5) @(negedge clk);
        chk(phase == 0 && pc == 0, "R2 hold without q_tick", {phase, pc}, 32'h0);

        // R5 branch-if-not-carry taken, +5 -> 12
        run_instr(16'hE305, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(pc == 21'd12, "R5 BNC taken +5", pc, 12);
        // R6 not taken
        run_instr(16'hE305, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(pc == 21'd14, "R6 BNC not taken", pc, 14);
        // R5 negative offset, branch-if-not-negative
        run_instr(16'hE7FD, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(pc == 21'd10, "R5 BNN taken -3", pc, 10);
        run_instr(16'hE7FD, 1'b0, 1'b1, 1'b0, 1'b0);

        // R4 every condition code with its flag at 0 and 1
        for (int cc = 0; cc < 8; cc++) begin
            for (int fv = 0; fv < 2; fv++) begin
                bit b;
                b = fv[0];
                unique case (cc / 2)
                    0: run_instr({5'b11100, 3'(cc), 8'h04}, ~b, ~b, b, ~b);
                    1: run_instr({5'b11100, 3'(cc), 8'h04}, b, ~b, ~b, ~b);
                    2: run_instr({5'b11100, 3'(cc), 8'h04}, ~b, ~b, ~b, b);
                    default: run_instr({5'b11100, 3'(cc), 8'h04}, ~b, b, ~b, ~b);
                endcase
            end
        end

        // R3 words outside the branch prefix, flags that satisfy every test
        run_instr(16'hE800, 1'b1, 1'b1, 1'b1, 1'b1);
        run_instr(16'hF123, 1'b0, 1'b0, 1'b0, 1'b0);
        run_instr(16'h0000, 1'b1, 1'b0, 1'b1, 1'b0);

        // R5 max positive offset
        run_instr(16'hE37F, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10 wrap from address 0 with -128
        do_reset();
        run_instr(16'hE380, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(pc == 21'h1FFF02, "R10 wrap modulo 2^21", pc, 21'h1FFF02);
        chk(cycle_cnt == 16'd2, "R9 taken costs two cycles", cycle_cnt, 2);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule